// File: doc/BRIEF.md
# In-Order Dual-Retire Completion Queue

This block follows instructions from the moment dispatch hands them to execution until they leave the machine in program order. A small ring of five slots holds one slot per instruction in flight. Dispatch raises a request for each new instruction. It receives the slot number, which is used as a tag, or a stall when every slot is taken. Execution units later report completion against that tag, with an optional exception flag.

Each cycle the two oldest slots are examined. If the oldest has completed cleanly it retires, and the next-oldest may retire with it in the same cycle when it has also completed cleanly. A completed entry that carries an exception does not retire. It holds back everything younger and raises a recovery request while it sits at the head. A flush input, used for mispredict or exception recovery, discards every entry in one cycle. Because retirement is strictly ordered, recovery always starts from a precise architectural state.

Top module: `inorder_retire_q`

## Requirements
- R1: After reset the queue is empty. `occupancy` is 0, `alloc_stall` is low, `alloc_tag` is 0, both `ret_vld` bits are low and `exc_flush_req` is low.
- R2: A request with `alloc_stall` low and `flush` low allocates exactly one slot. The slot gets tag `alloc_tag`, and successive allocations take tags 0,1,2,3,4,0,... (increment modulo 5).
- R3: `alloc_stall` is high exactly when all five slots are occupied. A request in that cycle allocates nothing and does not advance `alloc_tag`.
- R4: `fin_vld` with `fin_tag` marks that occupied slot as completed and records `fin_exc`. A report naming an unoccupied slot has no effect.
- R5: Bit 0 of `ret_vld` retires the oldest entry, whose tag appears on `ret_tag0`. Bit 1 retires the next-oldest entry, whose tag is `ret_tag0`+1 modulo 5, on `ret_tag1`. Bit 1 is never set without bit 0. An entry retires only when it has completed without exception.
- R6: A completed entry with an exception at the head raises `exc_flush_req` and retires nothing. An exception entry in second place stops retirement after the head entry.
- R7: `flush` suppresses retirement in its own cycle and overrides any allocation request. From the next cycle the queue is empty and the next tag is 0.
- R8: Without flush, `occupancy` next cycle equals its current value plus the accepted allocation minus the number of entries retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Dispatch asks for one slot |
| alloc_stall | output | 1 | All slots occupied, request refused |
| alloc_tag | output | 3 | Tag given to an accepted request |
| fin_vld | input | 1 | Completion report valid |
| fin_tag | input | 3 | Slot the report refers to |
| fin_exc | input | 1 | Completed instruction raised an exception |
| flush | input | 1 | Discard all entries |
| ret_vld | output | 2 | Retire strobes, bit 0 oldest |
| ret_tag0 | output | 3 | Tag retiring through bit 0 |
| ret_tag1 | output | 3 | Tag retiring through bit 1 |
| exc_flush_req | output | 1 | Exception entry reached the head |
| occupancy | output | 3 | Number of occupied slots |

## Verification
The random completion order is the main stimulus. Completions often arrive for younger entries first, which separates a design that waits for the head from one that retires whatever has finished. A high allocation rate keeps the ring full for long stretches and wraps the tags repeatedly. This exposes stall timing and modulo-5 pointer errors. Rare exception flags and both random and exception-triggered flushes show whether blocked entries stay blocked and whether flush wins over a simultaneous request. Stray completion reports to free slots show whether a dead slot can be marked completed by mistake.

// File: rtl/rtq_pkg.sv
package rtq_pkg;

    typedef struct packed {
        logic valid;
        logic done;
        logic exc;
    } slot_t;

    function automatic int ring_next(input int p, input int depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/rtq_slot.sv
module rtq_slot
    import rtq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  alloc_i,
    input  logic  clear_i,
    input  logic  fin_i,
    input  logic  fin_exc_i,
    output slot_t state_o
);
    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d = '0;
        end else if (alloc_i) begin
            s_d = '{valid: 1'b1, done: 1'b0, exc: 1'b0};
        end else if (fin_i && s_q.valid) begin
            s_d.done = 1'b1;
            s_d.exc  = fin_exc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign state_o = s_q;
endmodule

// File: rtl/rtq_retire_sel.sv
module rtq_retire_sel
    import rtq_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int TAG_W = 3
) (
    input  logic [DEPTH-1:0] v_i,
    input  logic [DEPTH-1:0] d_i,
    input  logic [DEPTH-1:0] e_i,
    input  logic [TAG_W-1:0] head_i,
    output logic             r0_o,
    output logic             r1_o,
    output logic [TAG_W-1:0] tag0_o,
    output logic [TAG_W-1:0] tag1_o,
    output logic             exc_o
);
    logic ok0, ok1;

    always_comb begin
        tag0_o = head_i;
        tag1_o = TAG_W'(ring_next(int'(head_i), DEPTH));
        ok0    = v_i[head_i] & d_i[head_i];
        ok1    = v_i[tag1_o] & d_i[tag1_o] & ~e_i[tag1_o];
        exc_o  = ok0 & e_i[head_i];
        r0_o   = ok0 & ~e_i[head_i];
        r1_o   = r0_o & ok1;
    end
endmodule

// File: rtl/inorder_retire_q.sv
module inorder_retire_q
    import rtq_pkg::*;
#(
    parameter int DEPTH = 5,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    output logic             alloc_stall,
    output logic [TAG_W-1:0] alloc_tag,
    input  logic             fin_vld,
    input  logic [TAG_W-1:0] fin_tag,
    input  logic             fin_exc,
    input  logic             flush,
    output logic [1:0]       ret_vld,
    output logic [TAG_W-1:0] ret_tag0,
    output logic [TAG_W-1:0] ret_tag1,
    output logic             exc_flush_req,
    output logic [CNT_W-1:0] occupancy
);
    typedef struct packed {
        logic [TAG_W-1:0] head;
        logic [TAG_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [DEPTH-1:0] v_vec, d_vec, e_vec;
    logic             raw_r0, raw_r1;
    logic [TAG_W-1:0] t0, t1;
    logic             accept, r0, r1;
    logic [CNT_W-1:0] nret;

    rtq_retire_sel #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_sel (
        .v_i(v_vec), .d_i(d_vec), .e_i(e_vec), .head_i(ctl_q.head),
        .r0_o(raw_r0), .r1_o(raw_r1), .tag0_o(t0), .tag1_o(t1),
        .exc_o(exc_flush_req)
    );

    always_comb begin
        alloc_stall = (ctl_q.count == CNT_W'(DEPTH));
        accept      = alloc_req & ~alloc_stall & ~flush;
        r0          = raw_r0 & ~flush;
        r1          = raw_r1 & ~flush;
        nret        = CNT_W'(r0) + CNT_W'(r1);
        ctl_d       = ctl_q;
        if (flush) begin
            ctl_d = '0;
        end else begin
            if (r1)      ctl_d.head = TAG_W'(ring_next(int'(t1), DEPTH));
            else if (r0) ctl_d.head = t1;
            if (accept)  ctl_d.tail = TAG_W'(ring_next(int'(ctl_q.tail), DEPTH));
            ctl_d.count = ctl_q.count + CNT_W'(accept) - nret;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        slot_t st;
        rtq_slot i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc_i  (accept && ctl_q.tail == TAG_W'(g)),
            .clear_i  (flush || (r0 && t0 == TAG_W'(g)) || (r1 && t1 == TAG_W'(g))),
            .fin_i    (fin_vld && !flush && fin_tag == TAG_W'(g)),
            .fin_exc_i(fin_exc),
            .state_o  (st)
        );
        assign v_vec[g] = st.valid;
        assign d_vec[g] = st.done;
        assign e_vec[g] = st.exc;
    end

    assign alloc_tag = ctl_q.tail;
    assign ret_vld   = {r1, r0};
    assign ret_tag0  = t0;
    assign ret_tag1  = t1;
    assign occupancy = ctl_q.count;
endmodule

// File: rtl/rtq_chk.sv
module rtq_chk #(
    parameter int DEPTH = 5,
    parameter int TAG_W = 3,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_req,
    input logic             alloc_stall,
    input logic             flush,
    input logic [1:0]       ret_vld,
    input logic [TAG_W-1:0] ret_tag0,
    input logic [TAG_W-1:0] ret_tag1,
    input logic             exc_flush_req,
    input logic [CNT_W-1:0] occupancy
);
    // R3
    stall_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_stall |=> (occupancy <= $past(occupancy)));

    // R5
    second_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld[1] |-> ret_vld[0]);

    // R5
    second_is_next_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld[1] |-> (int'(ret_tag1) == ((int'(ret_tag0) + 1) % DEPTH)));

    // R6
    exc_blocks_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flush_req |-> (ret_vld == 2'b00));

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occupancy == '0 && ret_vld == 2'b00 && !alloc_stall));

    // R8
    count_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (int'(occupancy) == int'($past(occupancy))
                    + int'($past(alloc_req && !alloc_stall))
                    - int'($past(ret_vld[0])) - int'($past(ret_vld[1]))));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy) <= DEPTH);
endmodule

bind inorder_retire_q rtq_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) i_rtq_chk (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_stall(alloc_stall),
    .flush(flush), .ret_vld(ret_vld), .ret_tag0(ret_tag0), .ret_tag1(ret_tag1),
    .exc_flush_req(exc_flush_req), .occupancy(occupancy)
);

// File: tb/test_inorder_retire_q.sv
`timescale 1ns/1ps
module test_inorder_retire_q;
    localparam int N = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_req = 1'b0;
    logic       alloc_stall;
    logic [2:0] alloc_tag;
    logic       fin_vld = 1'b0;
    logic [2:0] fin_tag = '0;
    logic       fin_exc = 1'b0;
    logic       flush = 1'b0;
    logic [1:0] ret_vld;
    logic [2:0] ret_tag0, ret_tag1;
    logic       exc_flush_req;
    logic [2:0] occupancy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int order[$];     // tags oldest first
    bit mdone[N];
    bit mexc[N];
    int next_tag = 0;

    always #2 clk = ~clk;

    inorder_retire_q i_inorder_retire_q (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_stall(alloc_stall),
        .alloc_tag(alloc_tag), .fin_vld(fin_vld), .fin_tag(fin_tag), .fin_exc(fin_exc),
        .flush(flush), .ret_vld(ret_vld), .ret_tag0(ret_tag0), .ret_tag1(ret_tag1),
        .exc_flush_req(exc_flush_req), .occupancy(occupancy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit in_q(input int t);
        foreach (order[i]) if (order[i] == t) return 1;
        return 0;
    endfunction

    // compare outputs with the model for the inputs currently driven
    task automatic compare();
        bit e0, e1, ex;
        int sz = order.size();
        e0 = !flush && sz > 0 && mdone[order[0]] && !mexc[order[0]];
        e1 = e0 && sz > 1 && mdone[order[1]] && !mexc[order[1]];
        ex = sz > 0 && mdone[order[0]] && mexc[order[0]];
        check(occupancy == 3'(sz), "R8 occupancy", occupancy, sz);
        check(alloc_stall == (sz == N), "R3 stall", alloc_stall, sz == N);
        check(alloc_tag == 3'(next_tag), "R2 alloc_tag", alloc_tag, next_tag);
        check(ret_vld[0] == e0, "R5 ret_vld0", ret_vld[0], e0);
        check(ret_vld[1] == e1, "R5 ret_vld1", ret_vld[1], e1);
        if (e0) check(ret_tag0 == 3'(order[0]), "R5 ret_tag0", ret_tag0, order[0]);
        if (e1) check(ret_tag1 == 3'(order[1]), "R5 ret_tag1", ret_tag1, order[1]);
        check(exc_flush_req == ex, "R6 exc_flush_req", exc_flush_req, ex);
    endtask

    task automatic model_step();
        bit e0, e1;
        e0 = !flush && order.size() > 0 && mdone[order[0]] && !mexc[order[0]];
        e1 = e0 && order.size() > 1 && mdone[order[1]] && !mexc[order[1]];
        if (flush) begin
            order.delete();
            next_tag = 0;
            return;
        end
        if (e0) void'(order.pop_front());
        if (e1) void'(order.pop_front());
        if (fin_vld && in_q(int'(fin_tag))) begin   // R4: free slots ignored
            mdone[fin_tag] = 1;
            mexc[fin_tag]  = fin_exc;
        end
        if (alloc_req && order.size() + (e0 ? 1 : 0) + (e1 ? 1 : 0) < N) begin
            order.push_back(next_tag);
            mdone[next_tag] = 0;
            mexc[next_tag]  = 0;
            next_tag = (next_tag + 1) % N;
        end
    endtask

    task automatic cycle();
        #1 compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(4ns * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1 reset state
        check(occupancy == 0, "R1 occupancy", occupancy, 0);
        check(alloc_stall == 0, "R1 stall", alloc_stall, 0);
        check(ret_vld == 0, "R1 ret_vld", ret_vld, 0);
        check(alloc_tag == 0, "R1 alloc_tag", alloc_tag, 0);
        check(exc_flush_req == 0, "R1 exc_flush_req", exc_flush_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 fill to full, then request while stalled
        for (int i = 0; i < 7; i++) begin
            alloc_req = 1'b1;
            cycle();
        end
        check(occupancy == 3'(N), "R3 full", occupancy, N);
        // R4 report to a younger entry first: nothing retires
        alloc_req = 1'b0;
        fin_vld = 1'b1; fin_tag = 3'd1; fin_exc = 1'b0;
        cycle();
        fin_tag = 3'd0;
        cycle();
        fin_vld = 1'b0;
        cycle();   // R5 tags 0 and 1 retire together
        // R6 exception in slot 2
        fin_vld = 1'b1; fin_tag = 3'd2; fin_exc = 1'b1;
        cycle();
        fin_vld = 1'b0; fin_exc = 1'b0;
        cycle();
        check(exc_flush_req == 1'b1, "R6 request", exc_flush_req, 1);
        // R7 flush with simultaneous request
        flush = 1'b1; alloc_req = 1'b1;
        cycle();
        flush = 1'b0; alloc_req = 1'b0;
        check(occupancy == 0, "R7 empty", occupancy, 0);
        check(alloc_tag == 0, "R7 tag reset", alloc_tag, 0);
        cycle();

        // random phase
        for (int c = 0; c < 20000; c++) begin
            alloc_req = ($urandom_range(0, 99) < 70);
            fin_vld = 1'b0; fin_exc = 1'b0;
            if (order.size() > 0 && $urandom_range(0, 99) < 60) begin
                fin_vld = 1'b1;
                fin_tag = 3'(order[$urandom_range(0, order.size() - 1)]);
                fin_exc = ($urandom_range(0, 99) < 4);
            end else if ($urandom_range(0, 99) < 15) begin
                fin_vld = 1'b1;
                fin_tag = 3'($urandom_range(0, N - 1));   // R4 may name a free slot
            end
            flush = ($urandom_range(0, 99) < 2) ||
                    (exc_flush_req && $urandom_range(0, 99) < 30);
            cycle();
        end
        flush = 1'b0; alloc_req = 1'b0; fin_vld = 1'b0;
        cycle();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule